// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block maps a local-bus address into a PCI bus address and cycle type through a small set of programmable windows. Each memory window is described by a base word and a map word. The base word sets where the window sits on the local side, how large it is, whether it is enabled and whether it is prefetchable. The map word sets where the window lands on the PCI side and which cycle type it produces. A final window is reserved for I/O. It spans a fixed 16 MB and always yields an I/O cycle.

Software loads the window words through a simple write port, one word per clock. Translation is purely combinational from the stored words. When several enabled windows contain the same address, the window with the lowest index supplies the result. Firmware relies on this rule: enlarging an earlier window hides a later one, and the later window can then be reprogrammed, for example to reach configuration space, while the earlier window keeps covering both memory regions.

Top module: `addr_window_xlate`

## Requirements
- R1: While reset is asserted and after it is released, every window is disabled, so the outputs show a miss: `hit`=0, `pci_addr`=0, `cyc_type`=0, `prefetch`=0.
- R2: A write with `wr_en`=1 stores `wr_data` into the word chosen by `wr_idx` and takes effect from the next rising edge. The index map is: 2i is the base of memory window i, 2i+1 is its map, 2N is the I/O base and 2N+1 is the I/O map, where N is the number of memory windows. Any other index changes nothing.
- R3: A memory window matches when base bit 0 is set and the address agrees with base bits 31:20 above the window size. The size code in base bits 7:4 selects 1 MB for code 0 and doubles with each step up to 2 GB for code 11. Codes 12 to 15 behave as code 11.
- R4: In a memory window, PCI address bits 31:20 take map bits 15:4 above the window size and the local address bits below it. Bits 19:2 always pass through unchanged.
- R5: A memory window drives `cyc_type` from map bits 3:1 (0 interrupt acknowledge, 1 I/O, 3 memory, 5 configuration, 6 memory-multiple) and drives `prefetch` from base bit 3.
- R6: In a memory window, PCI address bits 1:0 copy the local bits 1:0 when map bit 0 is set, and are zero when it is clear.
- R7: The I/O window matches when its base bit 0 is set and local bits 31:24 equal base bits 15:8. It yields PCI address {map bits 15:8, local bits 23:0}, cycle type 1 and `prefetch`=0.
- R8: When more than one enabled window contains the address, the window with the lowest index wins. Memory windows come before the I/O window.
- R9: An address outside every enabled window gives `hit`=0, `pci_addr`=0, `cyc_type`=0 and `prefetch`=0.
- R10: The outputs follow `lb_addr` in the same cycle, with no register between the address and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Window word write strobe |
| wr_idx | input | IDX_W (3) | Index of the window word to write |
| wr_data | input | 32 | Write data; map and I/O words use bits 15:0 |
| lb_addr | input | 32 | Local-bus address to translate |
| hit | output | 1 | Address lies in an enabled window |
| pci_addr | output | 32 | Translated PCI address |
| cyc_type | output | 3 | PCI cycle type |
| prefetch | output | 1 | Winning window is prefetchable |

## Verification
The assertions assume that `wr_en` and `wr_idx` are stable, known values at each rising edge. They also assume that `lb_addr` only changes between edges, so a stable address and no write in the previous cycle mean the translation must not move. The bench drives every input on the falling edge and samples one time unit later, well before the next rising edge. The window words it programs are chosen so that each overlap it exercises is deliberate: enlarging window 0 to hide window 1, and stretching window 0 to 2 GB with an out-of-range size code.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
   localparam int unsigned ADDR_W   = 32;
   localparam int unsigned MAP_W    = 16;
   localparam int unsigned MIN_SH   = 20;
   localparam int unsigned UPPER_W  = ADDR_W - MIN_SH;

   localparam logic [2:0] CYC_IACK    = 3'd0;
   localparam logic [2:0] CYC_IO      = 3'd1;
   localparam logic [2:0] CYC_MEM     = 3'd3;
   localparam logic [2:0] CYC_CFG     = 3'd5;
   localparam logic [2:0] CYC_MEMMULT = 3'd6;

   typedef struct packed {
      logic              hit;
      logic [ADDR_W-1:0] addr;
      logic [2:0]        cyc;
      logic              pf;
   } xlate_res_t;
endpackage

// File: rtl/win_regs.sv
module win_regs
   import xlate_pkg::*;
#(
   parameter int unsigned NUM_MEM_WIN = 2,
   localparam int unsigned NUM_WORDS  = 2 * NUM_MEM_WIN + 2,
   localparam int unsigned IDX_W      = $clog2(NUM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] mem_base [NUM_MEM_WIN],
   output logic [MAP_W-1:0]  mem_map  [NUM_MEM_WIN],
   output logic [MAP_W-1:0]  io_base,
   output logic [MAP_W-1:0]  io_map
);
   for (genvar g = 0; g < NUM_MEM_WIN; g++) begin : g_mem
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_base[g] <= '0;
            mem_map[g]  <= '0;
         end else if (wr_en) begin
            if (wr_idx == IDX_W'(2 * g))     mem_base[g] <= wr_data;
            if (wr_idx == IDX_W'(2 * g + 1)) mem_map[g]  <= wr_data[MAP_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_base <= '0;
         io_map  <= '0;
      end else if (wr_en) begin
         if (wr_idx == IDX_W'(2 * NUM_MEM_WIN))     io_base <= wr_data[MAP_W-1:0];
         if (wr_idx == IDX_W'(2 * NUM_MEM_WIN + 1)) io_map  <= wr_data[MAP_W-1:0];
      end
   end
endmodule

// File: rtl/mem_window.sv
module mem_window
   import xlate_pkg::*;
#(
   parameter int unsigned MAX_SIZE_CODE = 11
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [MAP_W-1:0]  map,
   input  logic [ADDR_W-1:0] addr,
   output xlate_res_t        res
);
   logic [3:0]         code_raw;
   logic [3:0]         code;
   logic [UPPER_W-1:0] keep_mask;
   logic [UPPER_W-1:0] up_hi;

   assign code_raw  = base[7:4];
   assign code      = (code_raw > 4'(MAX_SIZE_CODE)) ? 4'(MAX_SIZE_CODE) : code_raw;
   assign keep_mask = {UPPER_W{1'b1}} << code;
   assign up_hi     = (map[MAP_W-1:4] & keep_mask) | (addr[ADDR_W-1:MIN_SH] & ~keep_mask);

   always_comb begin
      res.hit  = base[0] &&
                 (((addr[ADDR_W-1:MIN_SH] ^ base[ADDR_W-1:MIN_SH]) & keep_mask) == '0);
      res.addr = {up_hi, addr[MIN_SH-1:2], (map[0] ? addr[1:0] : 2'b00)};
      res.cyc  = map[3:1];
      res.pf   = base[3];
   end
endmodule

// File: rtl/io_window.sv
module io_window
   import xlate_pkg::*;
(
   input  logic [MAP_W-1:0]  base,
   input  logic [MAP_W-1:0]  map,
   input  logic [ADDR_W-1:0] addr,
   output xlate_res_t        res
);
   always_comb begin
      res.hit  = base[0] && (addr[ADDR_W-1:24] == base[MAP_W-1:8]);
      res.addr = {map[MAP_W-1:8], addr[23:0]};
      res.cyc  = CYC_IO;
      res.pf   = 1'b0;
   end
endmodule

// File: rtl/win_select.sv
module win_select
   import xlate_pkg::*;
#(
   parameter int unsigned NUM_WIN = 3
) (
   input  xlate_res_t cand [NUM_WIN],
   output xlate_res_t win
);
   always_comb begin
      win = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (cand[i].hit) win = cand[i];
      end
   end
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
   import xlate_pkg::*;
#(
   parameter int unsigned NUM_MEM_WIN   = 2,
   parameter int unsigned MAX_SIZE_CODE = 11,
   localparam int unsigned NUM_WIN      = NUM_MEM_WIN + 1,
   localparam int unsigned IDX_W        = $clog2(2 * NUM_MEM_WIN + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] lb_addr,
   output logic              hit,
   output logic [ADDR_W-1:0] pci_addr,
   output logic [2:0]        cyc_type,
   output logic              prefetch
);
   if (NUM_MEM_WIN < 1 || NUM_MEM_WIN > 6) begin : g_bad_num
      $error("NUM_MEM_WIN must lie in 1..6");
   end
   if (MAX_SIZE_CODE > UPPER_W - 1) begin : g_bad_size
      $error("MAX_SIZE_CODE exceeds the address width");
   end

   logic [ADDR_W-1:0] mem_base [NUM_MEM_WIN];
   logic [MAP_W-1:0]  mem_map  [NUM_MEM_WIN];
   logic [MAP_W-1:0]  io_base;
   logic [MAP_W-1:0]  io_map;
   xlate_res_t        cand [NUM_WIN];
   xlate_res_t        win;

   win_regs #(.NUM_MEM_WIN(NUM_MEM_WIN)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .mem_base (mem_base),
      .mem_map  (mem_map),
      .io_base  (io_base),
      .io_map   (io_map)
   );

   for (genvar g = 0; g < NUM_MEM_WIN; g++) begin : g_mwin
      mem_window #(.MAX_SIZE_CODE(MAX_SIZE_CODE)) u_mwin (
         .base (mem_base[g]),
         .map  (mem_map[g]),
         .addr (lb_addr),
         .res  (cand[g])
      );
   end

   io_window u_iowin (
      .base (io_base),
      .map  (io_map),
      .addr (lb_addr),
      .res  (cand[NUM_MEM_WIN])
   );

   win_select #(.NUM_WIN(NUM_WIN)) u_sel (
      .cand (cand),
      .win  (win)
   );

   assign hit      = win.hit;
   assign pci_addr = win.addr;
   assign cyc_type = win.cyc;
   assign prefetch = win.pf;
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk
   import xlate_pkg::*;
#(
   parameter int unsigned IDX_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [ADDR_W-1:0] lb_addr,
   input logic              hit,
   input logic [ADDR_W-1:0] pci_addr,
   input logic [2:0]        cyc_type,
   input logic              prefetch
);
   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_miss_chk: assert (!hit && pci_addr == '0);
      end
   end

   // R9
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (pci_addr == '0 && cyc_type == 3'd0 && !prefetch));

   // R4
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> pci_addr[19:2] == lb_addr[19:2]);

   // R6
   low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && pci_addr[1:0] != lb_addr[1:0]) |-> pci_addr[1:0] == 2'b00);

   // R10
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && $stable(lb_addr)) |-> ($stable(hit) && $stable(pci_addr)));

   // R5
   pf_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prefetch |-> hit);
endmodule

bind addr_window_xlate xlate_chk #(.IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_idx   (wr_idx),
   .lb_addr  (lb_addr),
   .hit      (hit),
   .pci_addr (pci_addr),
   .cyc_type (cyc_type),
   .prefetch (prefetch)
);

// File: tb/sim_addr_window_xlate.sv
`timescale 1ns/1ps
module sim_addr_window_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] lb_addr = '0;
   logic        hit;
   logic [31:0] pci_addr;
   logic [2:0]  cyc_type;
   logic        prefetch;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   addr_window_xlate u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .lb_addr(lb_addr), .hit(hit),
      .pci_addr(pci_addr), .cyc_type(cyc_type), .prefetch(prefetch)
   );

   typedef struct packed {
      logic [31:0] a;
      logic        h;
      logic [31:0] p;
      logic [2:0]  t;
      logic        f;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{32'h4123_4567, 1'b1, 32'h0123_4564, 3'd3, 1'b0},  // R3 R4 window 0
      '{32'h5ABC_DEF3, 1'b1, 32'h1ABC_DEF0, 3'd6, 1'b1},  // R4 R5 window 1
      '{32'h60AB_CDEF, 1'b1, 32'h00AB_CDEF, 3'd1, 1'b0},  // R7 I/O window
      '{32'h7000_0000, 1'b0, 32'h0000_0000, 3'd0, 1'b0},  // R9
      '{32'h3FFF_FFFF, 1'b0, 32'h0000_0000, 3'd0, 1'b0},  // R9 below window 0
      '{32'h4FFF_FFFF, 1'b1, 32'h0FFF_FFFC, 3'd3, 1'b0},  // R3 top of window 0
      '{32'h5000_0000, 1'b1, 32'h1000_0000, 3'd6, 1'b1},  // R3 bottom of window 1
      '{32'h6100_0000, 1'b0, 32'h0000_0000, 3'd0, 1'b0}   // R7 16 MB edge
   };

   task automatic wr(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic expect_out(input string req, input logic h, input logic [31:0] p,
                             input logic [2:0] t, input logic f);
      checks++;
      if (hit !== h || pci_addr !== p || cyc_type !== t || prefetch !== f) begin
         errors++;
         $display("FAIL %s: got hit=%0b addr=%08h type=%0d pf=%0b, expected hit=%0b addr=%08h type=%0d pf=%0b",
                  req, hit, pci_addr, cyc_type, prefetch, h, p, t, f);
      end
   endtask

   task automatic probe(input string req, input logic [31:0] a, input logic h,
                        input logic [31:0] p, input logic [2:0] t, input logic f);
      @(negedge clk);
      lb_addr = a;
      #1;
      expect_out(req, h, p, t, f);
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      lb_addr = 32'h4000_0000;
      #20;
      expect_out("R1 in reset", 1'b0, 32'h0, 3'd0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      probe("R1 after reset", 32'h4000_0000, 1'b0, 32'h0, 3'd0, 1'b0);

      wr(3'd0, 32'h4000_0081);   // window 0: 256 MB, memory
      wr(3'd1, 32'h0000_0006);
      wr(3'd2, 32'h5000_0089);   // window 1: 256 MB, prefetchable
      wr(3'd3, 32'h0000_100C);
      wr(3'd4, 32'h0000_6001);   // I/O window at 0x60xx_xxxx
      wr(3'd5, 32'h0000_0000);

      for (int i = 0; i < 8; i++) begin
         probe($sformatf("R3/R4/R5/R7/R9 vector %0d", i),
               VEC[i].a, VEC[i].h, VEC[i].p, VEC[i].t, VEC[i].f);
      end

      // R10: output follows a new address within the same cycle
      @(negedge clk);
      lb_addr = 32'h4000_0010;
      #1;
      expect_out("R10 same-cycle", 1'b1, 32'h0000_0010, 3'd3, 1'b0);

      // R2 + R8: enlarge window 0 to 512 MB, hiding window 1
      @(negedge clk);
      lb_addr = 32'h5ABC_DEF3;
      wr_en = 1'b1; wr_idx = 3'd0; wr_data = 32'h4000_0091;
      #1;
      expect_out("R2 before edge", 1'b1, 32'h1ABC_DEF0, 3'd6, 1'b1);
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      expect_out("R8 window 0 hides window 1", 1'b1, 32'h1ABC_DEF0, 3'd3, 1'b0);

      // R5 + R6: window 1 reprogrammed as 16 MB configuration window with low bits
      wr(3'd2, 32'h6100_0041);
      wr(3'd3, 32'h0000_000B);
      probe("R5 R6 configuration cycle", 32'h6100_0A07, 1'b1, 32'h0000_0A07, 3'd5, 1'b0);

      // R2: unused indices change nothing
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd7, 32'hFFFF_FFFF);
      probe("R2 unused index", 32'h60AB_CDEF, 1'b1, 32'h00AB_CDEF, 3'd1, 1'b0);

      // R7 + R9: disable the I/O window
      wr(3'd4, 32'h0000_6000);
      probe("R7 disabled I/O window", 32'h60AB_CDEF, 1'b0, 32'h0, 3'd0, 1'b0);

      // R3: size code 15 behaves as 2 GB
      wr(3'd0, 32'h4000_00F1);
      probe("R3 size clamp", 32'h0000_0010, 1'b1, 32'h0000_0010, 3'd3, 1'b0);
      probe("R3 size clamp upper half", 32'h8000_0000, 1'b0, 32'h0, 3'd0, 1'b0);

      // R1: reset clears all windows again
      @(negedge clk);
      rst_n = 1'b0;
      lb_addr = 32'h4123_4567;
      #1;
      expect_out("R1 re-reset", 1'b0, 32'h0, 3'd0, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule